// File: doc/BRIEF.md
# Multi-Stream Strided Data Prefetcher

This block watches the stream of demand block addresses from a data cache and learns constant-stride access patterns. Each demand address falls into an aligned address region (its upper address bits). Every tracked region owns one table entry that trains on the differences between successive accesses. When three accesses in a region form a constant nonzero stride N (b, b+N, b+2N), the entry is confirmed. From then on it offers prefetch block addresses b+3N, b+4N and so on, at most a fixed number of lines ahead of the latest demand access in that stream.

Several regions are tracked at once. A new region replaces table entries in round-robin order. Prefetch requests leave on a single valid/ready channel, one per cycle at most. The requests are picked round-robin among confirmed streams that still have lookahead budget. Demand accesses have priority, so no request is offered in a cycle that carries a demand access. A next-line mode forces the stride to +1 with a lookahead of one line, so that an access to b makes b+1 the next request. Returned data, cache lookup and page limits belong to other blocks.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, every entry is empty and `pf_valid` is 0 until a stream is confirmed.
- R2: A region is tracked by address bits [ADDR_W-1:REGION_W] (REGION_W=8 by default). Its entry offers no prefetch until three accesses to it form the same nonzero stride N (b, b+N, b+2N).
- R3: Once a stream is confirmed, the first request carries b+3N. Each accepted request (`pf_valid` and `pf_ready` high at a clock edge) advances the next address by N.
- R4: A stream holds at most LOOKAHEAD (default 12) accepted requests beyond its latest demand access. Each demand access at last+N releases one more request. If none is outstanding, the next request becomes that access plus N.
- R5: On a confirmed stream, an access with a different nonzero difference D stops its prefetching and restarts training with stride D. One further access at +D confirms the stream again, and the next request is that access plus D.
- R6: Up to NUM_STREAMS (default 8) regions are tracked. An access to an untracked region takes the entry at a round-robin allocation pointer, which starts at entry 0 after reset. The previous contents of that entry are lost.
- R7: At most one request is offered per cycle, chosen round-robin among eligible streams, starting after the last stream served. `pf_valid` is 0 in any cycle with `acc_valid` high. While `pf_ready` is 0, the offered address is held.
- R8: With `next_line`=1, an access to block b sets stride +1 and makes b+1 the next request, with a lookahead limit of one line. An access to last+1 that follows an accepted request releases the following line.
- R9: An access equal to the last address of its stream's entry changes nothing in that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| next_line | input | 1 | 1: fixed stride +1, one line of lookahead |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_addr | input | ADDR_W | Demand block address |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Block address of the offered prefetch |

## Verification
A demand access updates its table entry at the clock edge that samples it. Its effect on `pf_valid` and `pf_addr` is therefore due in the first following cycle that has no demand access. An accepted request changes the offered address at the very edge that accepts it. The bench drives inputs on the falling edge and samples the outputs a quarter period later, so each sample reflects exactly the table state after the previous rising edge. The bench compares every cycle against a behavioural queue-free model of the table. Directed checks read the sample taken in the idle cycle that follows each stimulus.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ST_NEW  = 2'd0,
    ST_ONE  = 2'd1,
    ST_CONF = 2'd2
  } trn_state_e;
endpackage

// File: rtl/pf_stream_entry.sv
module pf_stream_entry
  import pf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REGION_W  = 8,
  parameter int LOOKAHEAD = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              alloc,
  input  logic              fire,
  output logic              hit,
  output logic              eligible,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int AHEAD_W = $clog2(LOOKAHEAD + 1);
  localparam int TAG_W   = ADDR_W - REGION_W;

  logic               vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [ADDR_W-1:0]  last_q, last_d;
  logic [ADDR_W-1:0]  stride_q, stride_d;
  logic [ADDR_W-1:0]  next_q, next_d;
  logic [AHEAD_W-1:0] ahead_q, ahead_d;
  trn_state_e         st_q, st_d;

  logic [ADDR_W-1:0]  diff;
  logic [AHEAD_W-1:0] limit;
  logic               upd_en;

  assign hit      = vld_q && (tag_q == acc_addr[ADDR_W-1:REGION_W]);
  assign limit    = seq_mode ? AHEAD_W'(1) : AHEAD_W'(LOOKAHEAD);
  assign eligible = vld_q && (st_q == ST_CONF) && (ahead_q < limit);
  assign pf_addr  = next_q;
  assign diff     = acc_addr - last_q;
  assign upd_en   = (acc_valid && (alloc || hit)) || fire;

  always_comb begin
    vld_d    = vld_q;
    tag_d    = tag_q;
    last_d   = last_q;
    stride_d = stride_q;
    next_d   = next_q;
    ahead_d  = ahead_q;
    st_d     = st_q;
    if (acc_valid && alloc) begin
      vld_d   = 1'b1;
      tag_d   = acc_addr[ADDR_W-1:REGION_W];
      last_d  = acc_addr;
      ahead_d = '0;
      if (seq_mode) begin
        st_d     = ST_CONF;
        stride_d = ADDR_W'(1);
        next_d   = acc_addr + ADDR_W'(1);
      end else begin
        st_d     = ST_NEW;
        stride_d = '0;
        next_d   = acc_addr;
      end
    end else if (acc_valid && hit) begin
      if (diff != '0) begin
        last_d = acc_addr;
        if (seq_mode) begin
          if (st_q == ST_CONF && stride_q == ADDR_W'(1) && diff == ADDR_W'(1)
              && ahead_q != '0) begin
            ahead_d = ahead_q - AHEAD_W'(1);
          end else begin
            st_d     = ST_CONF;
            stride_d = ADDR_W'(1);
            next_d   = acc_addr + ADDR_W'(1);
            ahead_d  = '0;
          end
        end else begin
          unique case (st_q)
            ST_NEW: begin
              stride_d = diff;
              st_d     = ST_ONE;
            end
            ST_ONE: begin
              if (diff == stride_q) begin
                st_d    = ST_CONF;
                next_d  = acc_addr + stride_q;
                ahead_d = '0;
              end else begin
                stride_d = diff;
              end
            end
            default: begin
              if (diff == stride_q) begin
                if (ahead_q == '0) next_d = acc_addr + stride_q;
                else               ahead_d = ahead_q - AHEAD_W'(1);
              end else begin
                st_d     = ST_ONE;
                stride_d = diff;
                ahead_d  = '0;
              end
            end
          endcase
        end
      end
    end else if (fire) begin
      next_d  = next_q + stride_q;
      ahead_d = ahead_q + AHEAD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      tag_q    <= '0;
      last_q   <= '0;
      stride_q <= '0;
      next_q   <= '0;
      ahead_q  <= '0;
      st_q     <= ST_NEW;
    end else if (upd_en) begin
      vld_q    <= vld_d;
      tag_q    <= tag_d;
      last_q   <= last_d;
      stride_q <= stride_d;
      next_q   <= next_d;
      ahead_q  <= ahead_d;
      st_q     <= st_d;
    end
  end

  AST_AHEAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ahead_q <= AHEAD_W'(LOOKAHEAD)); // R4
  AST_CONF_STRIDE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONF) |-> (stride_q != '0)); // R2
  AST_FIRE_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (eligible && !acc_valid)); // R7
  AST_FIRE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (next_q == $past(next_q) + stride_q)); // R3
endmodule

// File: rtl/pf_rr_arb.sv
module pf_rr_arb #(
  parameter int NUM   = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   req,
  input  logic             advance,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx,
  output logic [NUM-1:0]   gnt_oh
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_idx = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      int pos;
      pos = int'(ptr_q) + k;
      if (pos >= NUM) pos = pos - NUM;
      if (req[pos]) gnt_idx = IDX_W'(pos);
    end
    gnt_vld = |req;
    gnt_oh  = gnt_vld ? (NUM'(1) << gnt_idx) : '0;
    ptr_d   = ptr_q;
    if (advance && gnt_vld)
      ptr_d = (gnt_idx == IDX_W'(NUM - 1)) ? '0 : gnt_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh)); // R7
  AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]); // R7
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W      = 32,
  parameter int REGION_W    = 8,
  parameter int NUM_STREAMS = 8,
  parameter int LOOKAHEAD   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              next_line,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  logic                   rst_meta_q, rst_sync_q;
  logic [NUM_STREAMS-1:0] hit_vec, elig_vec, alloc_vec, fire_vec, req_vec, gnt_oh;
  logic [ADDR_W-1:0]      ent_addr [NUM_STREAMS];
  logic [IDX_W-1:0]       alloc_q, alloc_d, gnt_idx;
  logic                   any_hit, do_alloc, gnt_vld, pf_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign any_hit   = |hit_vec;
  assign do_alloc  = acc_valid && !any_hit;
  assign alloc_vec = do_alloc ? (NUM_STREAMS'(1) << alloc_q) : '0;
  assign alloc_d   = (alloc_q == IDX_W'(NUM_STREAMS - 1)) ? '0 : alloc_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)   alloc_q <= '0;
    else if (do_alloc) alloc_q <= alloc_d;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_STREAMS; g++) begin : g_ent
      pf_stream_entry #(
        .ADDR_W   (ADDR_W),
        .REGION_W (REGION_W),
        .LOOKAHEAD(LOOKAHEAD)
      ) u_ent (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .seq_mode (next_line),
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .alloc    (alloc_vec[g]),
        .fire     (fire_vec[g]),
        .hit      (hit_vec[g]),
        .eligible (elig_vec[g]),
        .pf_addr  (ent_addr[g])
      );
    end
  endgenerate

  assign req_vec = acc_valid ? '0 : elig_vec;

  pf_rr_arb #(
    .NUM  (NUM_STREAMS),
    .IDX_W(IDX_W)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .req    (req_vec),
    .advance(pf_fire),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx),
    .gnt_oh (gnt_oh)
  );

  assign pf_valid = gnt_vld;
  assign pf_addr  = ent_addr[gnt_idx];
  assign pf_fire  = pf_valid && pf_ready;
  assign fire_vec = pf_fire ? gnt_oh : '0;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(hit_vec)); // R6
  AST_NO_PF_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc_valid |-> !pf_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($past(pf_valid && !pf_ready && !acc_valid) && !acc_valid && $stable(next_line))
      |-> (pf_valid && pf_addr == $past(pf_addr))); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_sync_q |-> !pf_valid); // R1
endmodule

// File: tb/stride_prefetcher_tb.sv
module stride_prefetcher_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 8;
  localparam int LA    = 12;
  localparam int WD    = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        next_line;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  stride_prefetcher #(.ADDR_W(32), .REGION_W(8), .NUM_STREAMS(NS), .LOOKAHEAD(LA)) u_dut (
    .clk(clk), .rst_n(rst_n), .next_line(next_line), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural model of the stream table
  int          m_v [NS];
  int          m_st[NS];
  int          m_ah[NS];
  logic [31:0] m_last[NS];
  logic [31:0] m_str [NS];
  logic [31:0] m_next[NS];
  int          m_ap, m_ip;

  logic        obs_v;
  logic [31:0] obs_a;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) begin
      m_v[i] = 0; m_st[i] = 0; m_ah[i] = 0;
      m_last[i] = 0; m_str[i] = 0; m_next[i] = 0;
    end
    m_ap = 0; m_ip = 0;
  endtask

  task automatic model_pick(input logic av, output int idx);
    int lim;
    lim = next_line ? 1 : LA;
    idx = -1;
    if (!av) begin
      for (int k = 0; k < NS; k++) begin
        int j;
        j = (m_ip + k) % NS;
        if (idx < 0 && m_v[j] != 0 && m_st[j] == 2 && m_ah[j] < lim) idx = j;
      end
    end
  endtask

  task automatic model_access(input logic [31:0] a, input logic nl);
    int h;
    logic [31:0] d;
    h = -1;
    for (int i = 0; i < NS; i++)
      if (m_v[i] != 0 && m_last[i][31:8] == a[31:8]) h = i;
    if (h < 0) begin
      h = m_ap;
      m_ap = (m_ap + 1) % NS;
      m_v[h] = 1; m_last[h] = a; m_ah[h] = 0;
      if (nl) begin m_st[h] = 2; m_str[h] = 1; m_next[h] = a + 1; end
      else    begin m_st[h] = 0; m_str[h] = 0; m_next[h] = a; end
      return;
    end
    d = a - m_last[h];
    if (d == 0) return;
    m_last[h] = a;
    if (nl) begin
      if (m_st[h] == 2 && m_str[h] == 1 && d == 1 && m_ah[h] > 0) m_ah[h]--;
      else begin m_st[h] = 2; m_str[h] = 1; m_next[h] = a + 1; m_ah[h] = 0; end
    end else if (m_st[h] == 0) begin
      m_str[h] = d; m_st[h] = 1;
    end else if (m_st[h] == 1) begin
      if (d == m_str[h]) begin m_st[h] = 2; m_next[h] = a + d; m_ah[h] = 0; end
      else m_str[h] = d;
    end else begin
      if (d == m_str[h]) begin
        if (m_ah[h] == 0) m_next[h] = a + d;
        else m_ah[h]--;
      end else begin
        m_st[h] = 1; m_str[h] = d; m_ah[h] = 0;
      end
    end
  endtask

  // one clock: drive on falling edge, compare, then apply the model at the rising edge
  task automatic step(input logic av, input logic [31:0] a, input logic rdy);
    int idx;
    acc_valid = av; acc_addr = a; pf_ready = rdy;
    #(CLK_P/4);
    model_pick(av, idx);
    obs_v = pf_valid; obs_a = pf_addr;
    chk(pf_valid == (idx >= 0), "model pf_valid", {31'd0, pf_valid}, {31'd0, idx >= 0});
    if (idx >= 0) chk(pf_addr == m_next[idx], "model pf_addr", pf_addr, m_next[idx]);
    @(posedge clk);
    if (rst_n) begin
      if (av) model_access(a, next_line);
      else if (idx >= 0 && rdy) begin
        m_next[idx] = m_next[idx] + m_str[idx];
        m_ah[idx]++;
        m_ip = (idx + 1) % NS;
      end
    end
    @(negedge clk);
  endtask

  task automatic acc(input logic [31:0] a);
    step(1'b1, a, 1'b0);
  endtask

  task automatic idle(input logic rdy);
    step(1'b0, 32'd0, rdy);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (3) step(1'b0, 32'd0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 32'd0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] last_a;
    rst_n = 1'b0; next_line = 1'b0; acc_valid = 1'b0; acc_addr = '0; pf_ready = 1'b0;
    @(negedge clk);

    // ---- training, ordering, lookahead, stride break, repeat
    do_reset();
    idle(1'b0);
    chk(obs_v == 1'b0, "R1 idle after reset", {31'd0, obs_v}, 32'd0);
    acc(32'h100); idle(1'b0);
    chk(obs_v == 1'b0, "R2 one access", {31'd0, obs_v}, 32'd0);
    acc(32'h104); idle(1'b0);
    chk(obs_v == 1'b0, "R2 two accesses", {31'd0, obs_v}, 32'd0);
    acc(32'h104); idle(1'b0);
    chk(obs_v == 1'b0, "R9 repeat during training", {31'd0, obs_v}, 32'd0);
    acc(32'h108); idle(1'b0);
    chk(obs_v && obs_a == 32'h10C, "R3 first prefetch b+3N", obs_a, 32'h10C);
    idle(1'b0);
    chk(obs_v && obs_a == 32'h10C, "R7 held while not ready", obs_a, 32'h10C);
    idle(1'b1);
    chk(obs_a == 32'h10C, "R3 accepted b+3N", obs_a, 32'h10C);
    idle(1'b1);
    chk(obs_a == 32'h110, "R3 next in stride order", obs_a, 32'h110);
    n = 2; last_a = 32'h110;
    for (int i = 0; i < 20; i++) begin
      idle(1'b1);
      if (obs_v) begin n++; last_a = obs_a; end
    end
    chk(n == LA, "R4 lookahead count", n, LA);
    chk(last_a == 32'h138, "R4 furthest line", last_a, 32'h138);
    acc(32'h108); idle(1'b0);
    chk(obs_v == 1'b0, "R9 repeat keeps budget spent", {31'd0, obs_v}, 32'd0);
    acc(32'h10C); idle(1'b0);
    chk(obs_v && obs_a == 32'h13C, "R4 demand releases one line", obs_a, 32'h13C);
    idle(1'b1);
    acc(32'h120); idle(1'b1);
    chk(obs_v == 1'b0, "R5 stride break stops prefetch", {31'd0, obs_v}, 32'd0);
    acc(32'h134); idle(1'b0);
    chk(obs_v && obs_a == 32'h148, "R5 reconfirmed new stride", obs_a, 32'h148);

    // ---- replacement order
    do_reset();
    acc(32'h1000); acc(32'h1002); acc(32'h2000); acc(32'h2003);
    for (int r = 3; r <= 9; r++) acc(32'(r) << 12);
    idle(1'b0);
    chk(obs_v == 1'b0, "R6 no confirmed stream", {31'd0, obs_v}, 32'd0);
    acc(32'h2006); idle(1'b0);
    chk(obs_v && obs_a == 32'h2009, "R6 second entry survives", obs_a, 32'h2009);
    acc(32'h1004); idle(1'b0);
    chk(obs_v == 1'b0, "R6 round-robin replaced entry 1", {31'd0, obs_v}, 32'd0);

    // ---- round-robin issue between two streams
    do_reset();
    acc(32'h100); acc(32'h101); acc(32'h102);
    acc(32'h200); acc(32'h210);
    chk(obs_v == 1'b0, "R7 no offer during access", {31'd0, obs_v}, 32'd0);
    acc(32'h220);
    idle(1'b1); chk(obs_a == 32'h103, "R7 rr first", obs_a, 32'h103);
    idle(1'b1); chk(obs_a == 32'h230, "R7 rr second", obs_a, 32'h230);
    idle(1'b1); chk(obs_a == 32'h104, "R7 rr third", obs_a, 32'h104);
    idle(1'b1); chk(obs_a == 32'h240, "R7 rr fourth", obs_a, 32'h240);

    // ---- next-line mode
    do_reset();
    next_line = 1'b1;
    acc(32'h500); idle(1'b1);
    chk(obs_v && obs_a == 32'h501, "R8 b+1 offered", obs_a, 32'h501);
    idle(1'b1);
    chk(obs_v == 1'b0, "R8 one line lookahead", {31'd0, obs_v}, 32'd0);
    acc(32'h501); idle(1'b1);
    chk(obs_v && obs_a == 32'h502, "R8 sequential release", obs_a, 32'h502);
    acc(32'h510); idle(1'b0);
    chk(obs_v && obs_a == 32'h511, "R8 jump in region", obs_a, 32'h511);
    acc(32'h700); idle(1'b1);
    chk(obs_v, "R8 new region offered", {31'd0, obs_v}, 32'd1);
    idle(1'b1); idle(1'b1);
    next_line = 1'b0;
    idle(1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule